// File: doc/BRIEF.md
# Frame Header Strip and Insert Engine

This block edits every frame on a byte-wide receive stream before the frame reaches a LAN MAC. Three removal stages work on the received bytes in a fixed order. The leading stage drops a header of programmable length at the start of the frame body. The second stage drops a 4-byte label that sits directly behind that header. The third stage lets 12 address bytes through and then drops a 4-byte tag. The third stage counts only bytes that the first two stages kept, so its position moves with their settings. The block can also put a 14-byte or an 18-byte header, taken from a configuration vector, in front of the received bytes.

Both streams use a valid/ready handshake and carry start-of-frame and end-of-frame markers. Configuration arrives on static inputs and is captured once per frame, when a start-of-frame byte is first offered. A frame that ends inside a removal window is cut short: its end marker moves to the last byte actually sent. A frame that would send no bytes at all becomes a single error-flagged byte.

Top module: `frame_hdr_editor`

## Requirements
- R1: With `cfg_strip_en` high, the first `cfg_strip_len` (0 to 15) received bytes of the frame are deleted. With it low, no bytes are deleted by this stage.
- R2: With `cfg_label_en` high, the 4 received bytes that follow the first-stage window are deleted. That window is empty when `cfg_strip_en` is low, so the label window then starts at the first byte.
- R3: With `cfg_tag_en` high, among the received bytes that the first two stages keep, the first 12 pass and the next 4 are deleted.
- R4: `cfg_ins_mode` selects the inserted header: 2'b01 inserts 14 bytes, 2'b10 inserts 18 bytes, and 2'b00 or 2'b11 inserts nothing. Inserted byte k is `cfg_ins_hdr[143-8k -: 8]`, so the most significant byte goes first.
- R5: Inserted bytes leave the block before any received byte of the frame. `in_ready` stays low until all of them have been taken in, and they do not count toward the 12-byte pass of R3.
- R6: If a frame ends before a removal window closes, the bytes already kept are sent and `out_eof` is set on the last byte actually sent.
- R7: A frame that sends no bytes produces exactly one byte with data 8'h00 and `out_sof`, `out_eof` and `out_err` all high.
- R8: While `out_valid` is high and `out_ready` is low, the output byte and its flags stay stable. No byte is lost or duplicated under backpressure.
- R9: Configuration is sampled when a start-of-frame byte is first offered. Changes during the frame have no effect on that frame.
- R10: `out_sof` marks the first byte sent for a frame and `out_eof` marks the last. `out_err` is low on every byte except the R7 byte. After reset `out_valid` is low.
- R11: Bytes offered outside a frame (without `in_sof`, while no frame is open) are accepted and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_strip_en | input | 1 | Enable leading header removal |
| cfg_strip_len | input | 4 | Leading header length in bytes |
| cfg_label_en | input | 1 | Enable 4-byte label removal |
| cfg_tag_en | input | 1 | Enable 4-byte tag removal after 12 address bytes |
| cfg_ins_mode | input | 2 | Header insertion mode |
| cfg_ins_hdr | input | 144 | Header bytes to insert, byte 0 in the top bits |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input first byte of frame |
| in_eof | input | 1 | Input last byte of frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output first byte of frame |
| out_eof | output | 1 | Output last byte of frame |
| out_err | output | 1 | Output error byte for an empty frame |

## Verification
A wrong removal counter changes which payload bytes appear on `out_data`. The scoreboard sees this on the first misplaced byte of that frame, at most a handful of cycles after it is received. A fault in the held last byte or in the flush path shows up as an end marker on the wrong byte, or as a missing or extra byte. This is caught at the frame boundary or when the queue is drained. Frames that are sent again with random backpressure, and a configuration change in the middle of a frame, expose stall or sampling faults as duplicated, dropped or differently edited bytes.

// File: rtl/frame_hdr_editor.sv
module frame_hdr_editor #(
  parameter int HDR_BYTES   = 18,
  parameter int SHORT_BYTES = 14,
  parameter int LABEL_BYTES = 4,
  parameter int ADDR_BYTES  = 12,
  parameter int TAG_BYTES   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_strip_en,
  input  logic [3:0]             cfg_strip_len,
  input  logic                   cfg_label_en,
  input  logic                   cfg_tag_en,
  input  logic [1:0]             cfg_ins_mode,
  input  logic [8*HDR_BYTES-1:0] cfg_ins_hdr,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [7:0]             in_data,
  input  logic                   in_sof,
  input  logic                   in_eof,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [7:0]             out_data,
  output logic                   out_sof,
  output logic                   out_eof,
  output logic                   out_err
);
  localparam int HDR_W = 8 * HDR_BYTES;
  localparam int IW    = $clog2(HDR_BYTES + 1);
  localparam int CW    = $clog2(16 + LABEL_BYTES + ADDR_BYTES + TAG_BYTES + 1);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] LBL  = CW'(LABEL_BYTES);
  localparam logic [CW-1:0] A_LO = CW'(ADDR_BYTES);
  localparam logic [CW-1:0] A_HI = CW'(ADDR_BYTES + TAG_BYTES);

  typedef enum logic [1:0] {S_WAIT, S_INS, S_BODY, S_FLUSH} st_t;
  st_t st;

  logic             r_en1, r_en2, r_en3;
  logic [3:0]       r_len;
  logic [HDR_W-1:0] r_hdr;
  logic [IW-1:0]    r_ins_n, ins_i;
  logic [CW-1:0]    cnt_rx, cnt_sv;
  logic             first_pend;
  logic             h_vld, h_sof;
  logic [7:0]       h_data;

  logic [IW-1:0] ins_n_new;
  always_comb begin
    case (cfg_ins_mode)
      2'b01:   ins_n_new = IW'(SHORT_BYTES);
      2'b10:   ins_n_new = IW'(HDR_BYTES);
      default: ins_n_new = '0;
    endcase
  end

  wire           o_free = !out_valid || out_ready;
  wire [CW-1:0]  len1   = r_en1 ? CW'(r_len) : '0;
  wire           drop12 = (cnt_rx < len1) || (r_en2 && cnt_rx < len1 + LBL);
  wire           drop3  = r_en3 && cnt_sv >= A_LO && cnt_sv < A_HI;
  wire           keep   = !drop12 && !drop3;
  wire           take   = (st == S_BODY) && in_valid && in_ready;

  assign in_ready = (st == S_WAIT) ? !in_sof : ((st == S_BODY) && o_free);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_WAIT;
      r_en1 <= 1'b0; r_en2 <= 1'b0; r_en3 <= 1'b0; r_len <= '0;
      r_hdr <= '0; r_ins_n <= '0; ins_i <= '0;
      cnt_rx <= '0; cnt_sv <= '0; first_pend <= 1'b0;
      h_vld <= 1'b0; h_sof <= 1'b0; h_data <= '0;
      out_valid <= 1'b0; out_data <= '0;
      out_sof <= 1'b0; out_eof <= 1'b0; out_err <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (st)
        S_WAIT: if (in_valid && in_sof) begin
          r_en1 <= cfg_strip_en; r_len <= cfg_strip_len;
          r_en2 <= cfg_label_en; r_en3 <= cfg_tag_en;
          r_hdr <= cfg_ins_hdr;  r_ins_n <= ins_n_new;
          ins_i <= '0; cnt_rx <= '0; cnt_sv <= '0; first_pend <= 1'b1;
          st <= (ins_n_new != '0) ? S_INS : S_BODY;
        end
        S_INS: if (o_free) begin
          if (h_vld) begin
            out_valid <= 1'b1; out_data <= h_data;
            out_sof <= h_sof; out_eof <= 1'b0; out_err <= 1'b0;
          end
          h_vld <= 1'b1; h_data <= r_hdr[HDR_W-1 -: 8]; h_sof <= first_pend;
          first_pend <= 1'b0;
          r_hdr <= r_hdr << 8;
          ins_i <= ins_i + 1'b1;
          if (ins_i == r_ins_n - 1'b1) st <= S_BODY;
        end
        S_BODY: if (take) begin
          if (cnt_rx != CMAX) cnt_rx <= cnt_rx + 1'b1;
          if (!drop12 && cnt_sv != CMAX) cnt_sv <= cnt_sv + 1'b1;
          if (keep) begin
            if (h_vld) begin
              out_valid <= 1'b1; out_data <= h_data;
              out_sof <= h_sof; out_eof <= 1'b0; out_err <= 1'b0;
              h_data <= in_data; h_sof <= first_pend;
              if (in_eof) st <= S_FLUSH;
            end else if (in_eof) begin
              out_valid <= 1'b1; out_data <= in_data;
              out_sof <= first_pend; out_eof <= 1'b1; out_err <= 1'b0;
              st <= S_WAIT;
            end else begin
              h_vld <= 1'b1; h_data <= in_data; h_sof <= first_pend;
            end
            first_pend <= 1'b0;
          end else if (in_eof) begin
            out_valid <= 1'b1; out_eof <= 1'b1;
            if (h_vld) begin
              out_data <= h_data; out_sof <= h_sof; out_err <= 1'b0;
            end else begin
              out_data <= 8'h00; out_sof <= 1'b1; out_err <= 1'b1;
            end
            h_vld <= 1'b0;
            st <= S_WAIT;
          end
        end
        S_FLUSH: if (o_free) begin
          out_valid <= 1'b1; out_data <= h_data;
          out_sof <= h_sof; out_eof <= 1'b1; out_err <= 1'b0;
          h_vld <= 1'b0;
          st <= S_WAIT;
        end
        default: st <= S_WAIT;
      endcase
    end
  end

  logic mon_open;
  always_ff @(posedge clk) begin
    if (!rst_n) mon_open <= 1'b0;
    else if (out_valid && out_ready) mon_open <= !out_eof;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof) && $stable(out_err)); // R8
  AST_ERR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_sof && out_eof && out_data == 8'h00); // R7
  AST_INS_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_INS |-> !in_ready); // R5
  AST_SOF_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> !mon_open); // R10
  AST_MID_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sof |-> mon_open); // R10
  AST_FLUSH_HAS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_FLUSH |-> h_vld); // R6
endmodule

// File: tb/frame_hdr_editor_bench.sv
module frame_hdr_editor_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         cfg_strip_en = 0, cfg_label_en = 0, cfg_tag_en = 0;
  logic [3:0]   cfg_strip_len = 0;
  logic [1:0]   cfg_ins_mode = 0;
  logic [143:0] cfg_ins_hdr = '0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, out_ready = 1;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, out_sof, out_eof, out_err;
  logic [7:0] out_data;

  frame_hdr_editor u_frame_hdr_editor (
    .clk(clk), .rst_n(rst_n),
    .cfg_strip_en(cfg_strip_en), .cfg_strip_len(cfg_strip_len),
    .cfg_label_en(cfg_label_en), .cfg_tag_en(cfg_tag_en),
    .cfg_ins_mode(cfg_ins_mode), .cfg_ins_hdr(cfg_ins_hdr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_err(out_err));

  typedef struct packed { logic [7:0] d; logic s; logic e; logic x; } item_t;
  item_t q_exp[$];
  string q_tag[$];
  int checks = 0, fails = 0, wait_first = 0, cyc = 0;
  bit bp_en = 0, done = 0;

  function automatic void check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  function automatic void expect_frame(int n, int seed, string tag);
    item_t tmp[$];
    int ni, len1, sv;
    ni = (cfg_ins_mode == 2'b01) ? 14 : (cfg_ins_mode == 2'b10) ? 18 : 0;
    for (int k = 0; k < ni; k++) tmp.push_back({cfg_ins_hdr[143-8*k -: 8], 3'b000});
    len1 = cfg_strip_en ? int'(cfg_strip_len) : 0;
    sv = 0;
    for (int i = 0; i < n; i++) begin
      if (i < len1) continue;
      if (cfg_label_en && i < len1 + 4) continue;
      sv++;
      if (cfg_tag_en && sv > 12 && sv <= 16) continue;
      tmp.push_back({8'(seed + i), 3'b000});
    end
    if (tmp.size() == 0) tmp.push_back({8'h00, 3'b111});
    else begin
      tmp[0].s = 1'b1;
      tmp[tmp.size()-1].e = 1'b1;
    end
    foreach (tmp[k]) begin q_exp.push_back(tmp[k]); q_tag.push_back(tag); end
  endfunction

  task automatic drive_byte(logic [7:0] d, logic s, logic e, output int waits);
    waits = 0;
    @(negedge clk);
    in_valid = 1; in_data = d; in_sof = s; in_eof = e;
    #2;
    while (!in_ready) begin waits++; @(negedge clk); #2; end
    @(posedge clk); #1;
    in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  task automatic send_frame(int n, int seed, string tag, bit chg);
    int w;
    expect_frame(n, seed, tag);
    for (int i = 0; i < n; i++) begin
      drive_byte(8'(seed + i), i == 0, i == n - 1, w);
      if (i == 0) begin
        wait_first = w;
        if (chg) begin
          cfg_tag_en = ~cfg_tag_en; cfg_strip_len = cfg_strip_len + 4'd3;
          cfg_label_en = ~cfg_label_en;
        end
      end
    end
  endtask

  task automatic set_cfg(bit e1, int l, bit e2, bit e3, logic [1:0] m);
    @(negedge clk);
    cfg_strip_en = e1; cfg_strip_len = 4'(l); cfg_label_en = e2;
    cfg_tag_en = e3; cfg_ins_mode = m;
  endtask

  initial forever begin
    @(negedge clk);
    out_ready = bp_en ? ($urandom % 3 != 0) : 1'b1;
  end

  initial forever begin
    @(negedge clk); #2;
    if (rst_n && out_valid && out_ready) begin
      if (q_exp.size() == 0) check(0, "R8", "unexpected byte", int'(out_data), 0);
      else begin
        item_t ex;
        string tg;
        ex = q_exp.pop_front(); tg = q_tag.pop_front();
        check({out_data, out_sof, out_eof, out_err} == ex, tg, "byte{d,sof,eof,err}",
              int'({out_data, out_sof, out_eof, out_err}), int'(ex));
      end
    end
  end

  initial forever begin
    @(posedge clk); cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int w;
    for (int k = 0; k < 18; k++) cfg_ins_hdr[143-8*k -: 8] = 8'(8'hA0 + k);
    repeat (4) @(negedge clk);
    check(out_valid == 0, "R10", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1;
    @(negedge clk); #2;
    check(out_valid == 0, "R10", "out_valid after reset", int'(out_valid), 0);

    for (int pass = 0; pass < 2; pass++) begin
      bp_en = (pass == 1);
      set_cfg(0, 0, 0, 0, 2'b00); send_frame(20, 8'h10, "R10", 0);
      set_cfg(1, 6, 0, 0, 2'b00); send_frame(20, 8'h30, "R1", 0);
      set_cfg(0, 9, 0, 0, 2'b00); send_frame(12, 8'h50, "R1", 0);
      set_cfg(1, 5, 1, 0, 2'b00); send_frame(20, 8'h60, "R2", 0);
      set_cfg(0, 7, 1, 0, 2'b00); send_frame(16, 8'h80, "R2", 0);
      set_cfg(0, 0, 0, 1, 2'b00); send_frame(24, 8'h90, "R3", 0);
      set_cfg(1, 3, 1, 1, 2'b00); send_frame(30, 8'h20, "R3", 0);
      set_cfg(0, 0, 0, 1, 2'b01); send_frame(22, 8'h40, "R4", 0);
      if (!bp_en) check(wait_first >= 14, "R5", "input hold-off cycles", wait_first, 14);
      set_cfg(1, 2, 0, 0, 2'b10); send_frame(10, 8'h70, "R4", 0);
      if (!bp_en) check(wait_first >= 18, "R5", "input hold-off cycles", wait_first, 18);
      set_cfg(0, 0, 0, 0, 2'b11); send_frame(8, 8'hC0, "R4", 0);
      set_cfg(0, 0, 0, 1, 2'b00); send_frame(14, 8'hD0, "R6", 0);
      set_cfg(1, 4, 1, 0, 2'b00); send_frame(6, 8'hE0, "R6", 0);
      set_cfg(1, 10, 0, 0, 2'b00); send_frame(6, 8'hF0, "R7", 0);
      set_cfg(1, 3, 1, 1, 2'b10); send_frame(5, 8'h05, "R6", 0);
      set_cfg(1, 2, 0, 0, 2'b00); send_frame(24, 8'h11, "R9", 1);
      drive_byte(8'h99, 0, 0, w);
      drive_byte(8'h98, 0, 1, w);
      set_cfg(0, 0, 0, 0, 2'b00); send_frame(4, 8'hB0, "R11", 0);
      send_frame(1, 8'h33, "R10", 0);
    end

    bp_en = 0;
    for (int t = 0; t < 3000 && q_exp.size() != 0; t++) @(negedge clk);
    repeat (20) @(negedge clk);
    check(q_exp.size() == 0, "R8", "bytes still expected", q_exp.size(), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule